// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides which direction a memory controller's shared data bus serves, reads or writes. It watches how full the read and write queues are and a drain request, and it counts the accesses the scheduler issues in each direction. When the write backlog grows large enough, it moves the bus into write mode and raises a flag that stops further read scheduling.

The block leaves write mode under one of three conditions. The first is an empty write queue. The second is a backlog that has fallen well below the low watermark while no drain is in progress; a hysteresis margin stops the bus from flipping back and forth around that watermark. The third is waiting reads once enough writes have been issued in the current write period. On each write-to-read turn, the bus-busy deadline is pushed out by the turnaround penalty.

At every turn, the number of accesses issued in the period just ending is added to a run-length histogram for that direction, and the period counter then restarts from zero. The scheduler keeps the deadline up to date by loading a new value through a strobe, and the penalty is added on top of that value.

Top module: `rw_turn_arb`

## Requirements
- R1: After reset the block is in read mode: `wr_mode` and `rd_stop` are 0, `bus_busy_until` is 0, both period counters are zero and every histogram bin is zero.
- R2: In read mode, a write level at or above the high mark (WR_BUF*HI_PCT/100, rounded down) puts the block in write mode on the next clock edge. While in write mode, `rd_stop` is 1.
- R3: In read mode, `drain_req` with a non-zero write level enters write mode. `drain_req` with a write level of zero leaves the block in read mode.
- R4: In write mode, a write level of zero returns the block to read mode on the next edge, even while `drain_req` is held.
- R5: In write mode, if `drain_req` is low and write level + MIN_WR is strictly less than the low mark (WR_BUF*LO_PCT/100, rounded down), the block returns to read mode. A non-zero level that does not satisfy this, with no reads waiting and too few writes issued, keeps the block in write mode. `drain_req` blocks this exit.
- R6: In write mode, a non-zero read level returns the block to read mode once the writes issued in this period reach MIN_WR. A write strobe in the same cycle is counted before this test is made.
- R7: `bus_busy_until` takes `busy_val` when `busy_ld` is 1 and otherwise holds its value. On a write-to-read turn, T_WTR is added to that result.
- R8: On entry to write mode, the read count of the ending period is added to read histogram bin k. The count includes a read strobe in the same cycle. Bin k occupies `rd_hist[k*HW +: HW]`. The read count then restarts at zero.
- R9: On a return to read mode, the write count of the ending period, including a same-cycle write strobe, is added to write histogram bin k at `wr_hist[k*HW +: HW]`. The write count then restarts at zero.
- R10: A run length larger than the buffer size is recorded in the top bin (index RD_BUF for reads, WR_BUF for writes).
- R11: A histogram bin that holds its all-ones value stays there when it is hit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_level | input | $clog2(RD_BUF+1) | Read queue occupancy |
| wr_level | input | $clog2(WR_BUF+1) | Write queue occupancy |
| drain_req | input | 1 | Request to flush pending writes |
| rd_issue | input | 1 | A read access was issued this cycle |
| wr_issue | input | 1 | A write access was issued this cycle |
| busy_ld | input | 1 | Load a new bus-busy deadline |
| busy_val | input | TW | Deadline value to load |
| wr_mode | output | 1 | 1 while the bus serves writes |
| rd_stop | output | 1 | 1 while read scheduling is stopped |
| bus_busy_until | output | TW | Bus-busy deadline |
| rd_hist | output | (RD_BUF+1)*HW | Read run-length histogram, bin k at [k*HW +: HW] |
| wr_hist | output | (WR_BUF+1)*HW | Write run-length histogram, bin k at [k*HW +: HW] |

## Verification
The hardest case to reach is the tie between a write strobe and the exit test. The bench holds reads waiting and issues exactly MIN_WR writes, so the last strobe lands in the same cycle as the exit. A deadline load is timed for that same cycle, so the penalty must be added on top of the newly loaded value. Bin saturation is reached by building the bench with narrow histogram bins and driving a long run of empty read periods through back-to-back turns.

// File: rtl/rw_turn_arb.sv
module rw_turn_arb #(
  parameter int RD_BUF = 32,
  parameter int WR_BUF = 32,
  parameter int HI_PCT = 85,
  parameter int LO_PCT = 50,
  parameter int MIN_WR = 8,
  parameter int T_WTR  = 6,
  parameter int TW     = 32,
  parameter int HW     = 16,
  parameter int CW     = 16,
  localparam int RLW   = $clog2(RD_BUF + 1),
  localparam int WLW   = $clog2(WR_BUF + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RLW-1:0]           rd_level,
  input  logic [WLW-1:0]           wr_level,
  input  logic                     drain_req,
  input  logic                     rd_issue,
  input  logic                     wr_issue,
  input  logic                     busy_ld,
  input  logic [TW-1:0]            busy_val,
  output logic                     wr_mode,
  output logic                     rd_stop,
  output logic [TW-1:0]            bus_busy_until,
  output logic [(RD_BUF+1)*HW-1:0] rd_hist,
  output logic [(WR_BUF+1)*HW-1:0] wr_hist
);
  localparam int HI_TH = WR_BUF * HI_PCT / 100;
  localparam int LO_TH = WR_BUF * LO_PCT / 100;

  logic [CW-1:0] rd_cnt, wr_cnt, rd_nxt, wr_nxt;
  logic [TW-1:0] busy_base;
  logic          go_wr, go_rd;
  int            rd_bin, wr_bin;

  assign rd_nxt = (rd_issue && rd_cnt != '1) ? rd_cnt + 1'b1 : rd_cnt;
  assign wr_nxt = (wr_issue && wr_cnt != '1) ? wr_cnt + 1'b1 : wr_cnt;

  assign go_wr = !wr_mode &&
                 (int'(wr_level) >= HI_TH || (drain_req && wr_level != '0));
  assign go_rd = wr_mode &&
                 (wr_level == '0 ||
                  (int'(wr_level) + MIN_WR < LO_TH && !drain_req) ||
                  (rd_level != '0 && int'(wr_nxt) >= MIN_WR));

  assign rd_bin = (int'(rd_nxt) > RD_BUF) ? RD_BUF : int'(rd_nxt);
  assign wr_bin = (int'(wr_nxt) > WR_BUF) ? WR_BUF : int'(wr_nxt);

  assign busy_base = busy_ld ? busy_val : bus_busy_until;
  assign rd_stop   = wr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_mode        <= 1'b0;
      rd_cnt         <= '0;
      wr_cnt         <= '0;
      bus_busy_until <= '0;
    end else begin
      rd_cnt         <= go_wr ? '0 : rd_nxt;
      wr_cnt         <= go_rd ? '0 : wr_nxt;
      bus_busy_until <= go_rd ? busy_base + TW'(T_WTR) : busy_base;
      if (go_wr)      wr_mode <= 1'b1;
      else if (go_rd) wr_mode <= 1'b0;
    end
  end

  for (genvar i = 0; i <= RD_BUF; i++) begin : g_rbin
    logic [HW-1:0] bin;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bin <= '0;
      else if (go_wr && rd_bin == i && bin != '1) bin <= bin + 1'b1;
    end
    assign rd_hist[i*HW +: HW] = bin;
  end

  for (genvar i = 0; i <= WR_BUF; i++) begin : g_wbin
    logic [HW-1:0] bin;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bin <= '0;
      else if (go_rd && wr_bin == i && bin != '1) bin <= bin + 1'b1;
    end
    assign wr_hist[i*HW +: HW] = bin;
  end
endmodule

// File: rtl/rw_turn_arb_chk.sv
module rw_turn_arb_chk #(
  parameter int WR_BUF = 32,
  parameter int HI_PCT = 85,
  parameter int LO_PCT = 50,
  parameter int MIN_WR = 8,
  parameter int T_WTR  = 6,
  parameter int TW     = 32,
  parameter int RLW    = 6,
  parameter int WLW    = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RLW-1:0] rd_level,
  input logic [WLW-1:0] wr_level,
  input logic           drain_req,
  input logic           busy_ld,
  input logic           wr_mode,
  input logic           rd_stop,
  input logic [TW-1:0]  bus_busy_until
);
  localparam int HI_TH = WR_BUF * HI_PCT / 100;
  localparam int LO_TH = WR_BUF * LO_PCT / 100;

  AST_ENTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && int'(wr_level) >= HI_TH) |=> (wr_mode && rd_stop)); // R2
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && wr_level == '0) |=> !wr_mode); // R3
  AST_EXIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_level == '0) |=> (!wr_mode && !rd_stop)); // R4
  AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_level != '0 && rd_level == '0 &&
     (int'(wr_level) + MIN_WR >= LO_TH || drain_req)) |=> wr_mode); // R5
  AST_WTR_ADDED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_mode) && !$past(busy_ld)) |->
      bus_busy_until == $past(bus_busy_until) + TW'(T_WTR)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(wr_mode) && !$past(busy_ld)) |-> $stable(bus_busy_until)); // R7
endmodule

bind rw_turn_arb rw_turn_arb_chk #(
  .WR_BUF(WR_BUF), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT), .MIN_WR(MIN_WR),
  .T_WTR(T_WTR), .TW(TW), .RLW(RLW), .WLW(WLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_level(rd_level), .wr_level(wr_level),
  .drain_req(drain_req), .busy_ld(busy_ld), .wr_mode(wr_mode),
  .rd_stop(rd_stop), .bus_busy_until(bus_busy_until)
);

// File: tb/rw_turn_arb_tb.sv
module rw_turn_arb_tb;
  localparam int RD = 8, WR = 8, HIP = 75, LOP = 50, MINW = 2, TWTR = 5;
  localparam int TW = 16, HW = 4, CW = 8;
  localparam int HI = WR * HIP / 100;
  localparam int LO = WR * LOP / 100;
  localparam int HMAX = (1 << HW) - 1;

  logic clk = 0, rst_n = 0;
  logic [3:0] rd_level = 0, wr_level = 0;
  logic drain_req = 0, rd_issue = 0, wr_issue = 0, busy_ld = 0;
  logic [TW-1:0] busy_val = 0;
  logic wr_mode, rd_stop;
  logic [TW-1:0] bus_busy_until;
  logic [(RD+1)*HW-1:0] rd_hist;
  logic [(WR+1)*HW-1:0] wr_hist;

  int total = 0, bad = 0;
  int m_wm, m_rc, m_wc, m_busy;
  int m_rh[RD+1];
  int m_wh[WR+1];

  always #10 clk = ~clk;

  rw_turn_arb #(.RD_BUF(RD), .WR_BUF(WR), .HI_PCT(HIP), .LO_PCT(LOP),
    .MIN_WR(MINW), .T_WTR(TWTR), .TW(TW), .HW(HW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_level(rd_level), .wr_level(wr_level),
    .drain_req(drain_req), .rd_issue(rd_issue), .wr_issue(wr_issue),
    .busy_ld(busy_ld), .busy_val(busy_val), .wr_mode(wr_mode),
    .rd_stop(rd_stop), .bus_busy_until(bus_busy_until),
    .rd_hist(rd_hist), .wr_hist(wr_hist));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wm = 0; m_rc = 0; m_wc = 0; m_busy = 0;
      foreach (m_rh[k]) m_rh[k] = 0;
      foreach (m_wh[k]) m_wh[k] = 0;
    end else begin
      int rc, wc, nb, b;
      rc = (rd_issue && m_rc < 255) ? m_rc + 1 : m_rc;
      wc = (wr_issue && m_wc < 255) ? m_wc + 1 : m_wc;
      nb = busy_ld ? int'(busy_val) : m_busy;
      if (!m_wm) begin
        if (wr_level >= HI || (drain_req && wr_level > 0)) begin
          b = rc > RD ? RD : rc;
          if (m_rh[b] < HMAX) m_rh[b]++;
          rc = 0; m_wm = 1;
        end
      end else if (wr_level == 0 || (wr_level + MINW < LO && !drain_req) ||
                   (rd_level > 0 && wc >= MINW)) begin
        b = wc > WR ? WR : wc;
        if (m_wh[b] < HMAX) m_wh[b]++;
        wc = 0; m_wm = 0; nb = nb + TWTR;
      end
      m_rc = rc; m_wc = wc; m_busy = nb % (1 << TW);
    end
  end

  task automatic cmp(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rbin(int k); return int'(rd_hist[k*HW +: HW]); endfunction
  function automatic int wbin(int k); return int'(wr_hist[k*HW +: HW]); endfunction

  task automatic compare_all();
    cmp("R2 mode", int'(wr_mode), m_wm);
    cmp("R2 rd_stop", int'(rd_stop), m_wm);
    cmp("R7 busy", int'(bus_busy_until), m_busy);
    for (int k = 0; k <= RD; k++) cmp("R8 rd_hist", rbin(k), m_rh[k]);
    for (int k = 0; k <= WR; k++) cmp("R9 wr_hist", wbin(k), m_wh[k]);
  endtask

  task automatic step();
    @(posedge clk); #5;
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    // R1 reset state
    cmp("R1 mode", int'(wr_mode), 0);
    cmp("R1 rd_stop", int'(rd_stop), 0);
    cmp("R1 busy", int'(bus_busy_until), 0);
    for (int k = 0; k <= RD; k++) cmp("R1 rd_hist", rbin(k), 0);
    for (int k = 0; k <= WR; k++) cmp("R1 wr_hist", wbin(k), 0);

    // R2/R8: three reads, then high write level
    rd_issue = 1;
    repeat (3) step();
    rd_issue = 0; wr_level = 4'(HI);
    step();
    cmp("R2 enter", int'(wr_mode), 1);
    cmp("R2 stop", int'(rd_stop), 1);
    cmp("R8 bin3", rbin(3), 1);

    // R5: band holds, below band exits
    wr_level = 3; step();
    cmp("R5 hold", int'(wr_mode), 1);
    wr_level = 1; step();
    cmp("R5 exit", int'(wr_mode), 0);
    cmp("R7 wtr", int'(bus_busy_until), TWTR);
    cmp("R9 bin0", wbin(0), 1);

    // R3: drain with empty writes, then with pending writes
    wr_level = 0; drain_req = 1; step(); step();
    cmp("R3 idle", int'(wr_mode), 0);
    wr_level = 3; step();
    cmp("R3 drain", int'(wr_mode), 1);
    wr_level = 1; step();
    cmp("R5 drain blocks", int'(wr_mode), 1);
    wr_level = 0; step();
    cmp("R4 empty", int'(wr_mode), 0);
    cmp("R7 wtr2", int'(bus_busy_until), 2 * TWTR);
    drain_req = 0;

    // R6/R7: same-cycle write strobe and deadline load
    wr_level = 7; step();
    rd_level = 2; wr_level = 5; wr_issue = 1; step();
    cmp("R6 one write", int'(wr_mode), 1);
    busy_ld = 1; busy_val = 100; step();
    cmp("R6 exit", int'(wr_mode), 0);
    cmp("R7 load+wtr", int'(bus_busy_until), 100 + TWTR);
    cmp("R9 bin2", wbin(2), 1);
    wr_issue = 0; busy_ld = 0; rd_level = 0; wr_level = 0; step();
    cmp("R7 hold", int'(bus_busy_until), 100 + TWTR);

    // R10: oversize read run
    rd_issue = 1; repeat (10) step();
    rd_issue = 0; wr_level = 6; step();
    cmp("R10 top bin", rbin(RD), 1);
    wr_level = 0; step();

    // R11: saturate read bin 0
    for (int n = 0; n < 20; n++) begin
      wr_level = 7; step();
      wr_level = 0; step();
    end
    cmp("R11 saturate", rbin(0), HMAX);
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule